// File: doc/BRIEF.md
# Two-Step Flash Converter Digital Back End

This block is the digital half of an 8-bit subranging flash converter. On every falling clock edge it takes a 15-bit coarse thermometer word and turns it into the upper nibble of a new sample. It registers that nibble as the ladder segment select for whichever of two fine comparator banks owns the sample. On the next falling edge it reads that bank's 15-bit fine thermometer word to get the lower nibble.

The two fine banks take turns, bank A first after reset. Each bank therefore has a whole clock period to settle while the other bank serves the next sample, and the block still accepts one sample per cycle. The coarse and fine nibbles are joined in a correction stage on a further falling edge. The result is loaded into the output register on the rising edge that follows, so a sample appears 2.5 cycles after the falling edge that took it. The data pins float while the active-low output enable is high.

The comparator arrays, ladder and sampling switches lie outside this block and show up here only as thermometer inputs.

Top module: `subrange_adc_backend`

## Requirements
- R1: One new sample is accepted on every falling edge, and the output register takes one new result on every rising edge.
- R2: The result for the sample taken at falling edge k is on `dout` after the rising edge that follows falling edge k+2, which is 2.5 cycles.
- R3: `cur_bank` is cleared to bank A by reset and swaps on every falling edge. Sample k is steered to bank A for even k and bank B for odd k, counting from the first falling edge after reset. Its fine word is read from `fine_therm_a` or `fine_therm_b` on falling edge k+1.
- R4: `fine_tap_a` or `fine_tap_b` takes the coarse segment of the sample steered to that bank at that sample's falling edge, and holds it on the edge that serves the other bank.
- R5: The output is straight binary {coarse nibble, fine nibble}. All-ones input words give 8'hFF and all-zero words give 8'h00.
- R6: A thermometer word for value v has bits v-1..0 set. Each bit is replaced by the majority of itself and its two neighbours, taking 1 below bit 0 and 0 above bit 14, and the code is the index of the highest surviving 1 plus one. A single flipped bit at least two places from the transition is corrected exactly.
- R7: When `oe_n` is high, `dout` is high impedance. When it is low, `dout` drives the output register.
- R8: Synchronous reset clears the output register to 8'h00, `data_valid`, both tap selects and the bank pointer.
- R9: After reset, `data_valid` stays low until the first sample's result reaches the output register, and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; falling edge samples, rising edge loads output |
| rst | input | 1 | Synchronous active-high reset, seen on both edges |
| oe_n | input | 1 | Active-low output enable for `dout` |
| coarse_therm | input | 15 | Coarse comparator thermometer word |
| fine_therm_a | input | 15 | Fine bank A thermometer word |
| fine_therm_b | input | 15 | Fine bank B thermometer word |
| fine_tap_a | output | 4 | Ladder segment select for fine bank A |
| fine_tap_b | output | 4 | Ladder segment select for fine bank B |
| data_valid | output | 1 | High once results have reached the output register |
| dout | output | 8 | Converted code, three-state |

## Verification
A stream of codes is fed with one code per cycle.

- Codes 00 and FF show the full-scale ends.
- Codes 0F, F0, 7F and 80 sit on the nibble boundaries. A swapped or misaligned nibble shows up there at once.
- Codes 5A and A5 follow each other, so a fine word paired with the wrong bank's coarse segment gives a wrong code.
- Several words carry one flipped comparator bit in the coarse word, the fine word, or both. These separate the majority decoder from a plain ones count, which would be off by one.
- Checks on the tap selects, on `data_valid` during the first cycles, and on the output with enable high and low cover the steering, start-up and three-state paths.

// File: rtl/adc_be_pkg.sv
package adc_be_pkg;
  // which fine comparator bank is being sampled
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  // thermometer decoding variants
  localparam int DEC_ONES   = 0;
  localparam int DEC_SMOOTH = 1;
endpackage

// File: rtl/therm_decoder.sv
module therm_decoder #(
  parameter int CODE_W = 4,
  parameter int MODE   = adc_be_pkg::DEC_SMOOTH,
  localparam int TW    = (1 << CODE_W) - 1
) (
  input  logic [TW-1:0]     therm,
  output logic [CODE_W-1:0] code
);
  if (MODE == adc_be_pkg::DEC_ONES) begin : g_ones
    // plain population count
    always_comb begin
      code = '0;
      for (int i = 0; i < TW; i++) code = code + CODE_W'(therm[i]);
    end
  end else begin : g_smooth
    // pad: a 1 below the lowest bit, a 0 above the highest bit
    logic [TW+1:0] ext;
    logic [TW-1:0] sm;
    assign ext = {1'b0, therm, 1'b1};
    for (genvar i = 0; i < TW; i++) begin : g_bit
      assign sm[i] = (ext[i] & ext[i+1]) | (ext[i+1] & ext[i+2]) | (ext[i] & ext[i+2]);
    end
    always_comb begin
      code = '0;
      for (int i = 0; i < TW; i++) if (sm[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/bank_steer.sv
module bank_steer
  import adc_be_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] coarse_code,
  output bank_e             cur_bank,
  output logic [CODE_W-1:0] seg_a,
  output logic [CODE_W-1:0] seg_b,
  output logic              loaded_a,
  output logic              loaded_b
);
  localparam int NBANK = 2;

  logic [CODE_W-1:0] seg_q [NBANK];
  logic              ld_q  [NBANK];

  // bank pointer swaps every sampling edge
  always_ff @(negedge clk) begin
    if (rst) cur_bank <= BANK_A;
    else     cur_bank <= (cur_bank == BANK_A) ? BANK_B : BANK_A;
  end

  // per-bank coarse segment, written only when that bank takes the sample
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(negedge clk) begin
      if (rst) begin
        seg_q[b] <= '0;
        ld_q[b]  <= 1'b0;
      end else if (cur_bank == bank_e'(b)) begin
        seg_q[b] <= coarse_code;
        ld_q[b]  <= 1'b1;
      end
    end
  end

  assign seg_a    = seg_q[0];
  assign seg_b    = seg_q[1];
  assign loaded_a = ld_q[0];
  assign loaded_b = ld_q[1];
endmodule

// File: rtl/merge_pipe.sv
module merge_pipe
  import adc_be_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int FINE_W = 4,
  localparam int OUT_W = CODE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_e             dec_bank,
  input  logic [FINE_W-1:0] fine_a_code,
  input  logic [FINE_W-1:0] fine_b_code,
  input  logic [CODE_W-1:0] seg_a,
  input  logic [CODE_W-1:0] seg_b,
  input  logic              loaded_a,
  input  logic              loaded_b,
  output logic [OUT_W-1:0]  result,
  output logic              result_valid
);
  logic [CODE_W-1:0] nib_c;
  logic [FINE_W-1:0] nib_f;
  logic              v1, v2;
  logic [OUT_W-1:0]  merged;

  // fine decision: pair the deciding bank's fine nibble with its own coarse segment
  always_ff @(negedge clk) begin
    if (rst) begin
      nib_c <= '0;
      nib_f <= '0;
      v1    <= 1'b0;
    end else if (dec_bank == BANK_A) begin
      nib_c <= seg_a;
      nib_f <= fine_a_code;
      v1    <= loaded_a;
    end else begin
      nib_c <= seg_b;
      nib_f <= fine_b_code;
      v1    <= loaded_b;
    end
  end

  // correction stage: join the nibbles
  always_ff @(negedge clk) begin
    if (rst) begin
      merged <= '0;
      v2     <= 1'b0;
    end else begin
      merged <= {nib_c, nib_f};
      v2     <= v1;
    end
  end

  // output register on the rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result       <= merged;
      result_valid <= v2;
    end
  end
endmodule

// File: rtl/subrange_adc_backend.sv
module subrange_adc_backend
  import adc_be_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int FINE_W = 4,
  parameter int MODE   = DEC_SMOOTH,
  localparam int CTW   = (1 << CODE_W) - 1,
  localparam int FTW   = (1 << FINE_W) - 1,
  localparam int OUT_W = CODE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic [CTW-1:0]    coarse_therm,
  input  logic [FTW-1:0]    fine_therm_a,
  input  logic [FTW-1:0]    fine_therm_b,
  output logic [CODE_W-1:0] fine_tap_a,
  output logic [CODE_W-1:0] fine_tap_b,
  output logic              data_valid,
  output logic [OUT_W-1:0]  dout
);
  logic [CODE_W-1:0] coarse_code;
  logic [FINE_W-1:0] fine_code [2];
  bank_e             cur_bank;
  bank_e             dec_bank;
  logic              loaded_a, loaded_b;
  logic [OUT_W-1:0]  out_q;

  therm_decoder #(.CODE_W(CODE_W), .MODE(MODE)) u_dec_coarse (
    .therm(coarse_therm), .code(coarse_code)
  );

  for (genvar b = 0; b < 2; b++) begin : g_fine
    therm_decoder #(.CODE_W(FINE_W), .MODE(MODE)) u_dec_fine (
      .therm((b == 0) ? fine_therm_a : fine_therm_b), .code(fine_code[b])
    );
  end

  bank_steer #(.CODE_W(CODE_W)) u_steer (
    .clk(clk), .rst(rst), .coarse_code(coarse_code), .cur_bank(cur_bank),
    .seg_a(fine_tap_a), .seg_b(fine_tap_b), .loaded_a(loaded_a), .loaded_b(loaded_b)
  );

  // the bank that decides now is the one that sampled on the previous edge
  assign dec_bank = (cur_bank == BANK_A) ? BANK_B : BANK_A;

  merge_pipe #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_merge (
    .clk(clk), .rst(rst), .dec_bank(dec_bank),
    .fine_a_code(fine_code[0]), .fine_b_code(fine_code[1]),
    .seg_a(fine_tap_a), .seg_b(fine_tap_b),
    .loaded_a(loaded_a), .loaded_b(loaded_b),
    .result(out_q), .result_valid(data_valid)
  );

  assign dout = oe_n ? {OUT_W{1'bz}} : out_q;
endmodule

// File: rtl/adc_be_checker.sv
module adc_be_checker
  import adc_be_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input bank_e             cur_bank,
  input logic [CODE_W-1:0] tap_a,
  input logic [CODE_W-1:0] tap_b,
  input logic [OUT_W-1:0]  q,
  input logic              data_valid
);
  // R3: banks alternate each falling edge
  a_r3_a_to_b: assert property (@(negedge clk) disable iff (rst)
    (cur_bank == BANK_A) |=> (cur_bank == BANK_B));
  a_r3_b_to_a: assert property (@(negedge clk) disable iff (rst)
    (cur_bank == BANK_B) |=> (cur_bank == BANK_A));

  // R4: a bank's tap holds while the other bank samples
  a_r4_tap_a_hold: assert property (@(negedge clk) disable iff (rst)
    (cur_bank == BANK_B) |=> $stable(tap_a));
  a_r4_tap_b_hold: assert property (@(negedge clk) disable iff (rst)
    (cur_bank == BANK_A) |=> $stable(tap_b));

  // R8: reset clears output state and steering
  a_r8_reset_out: assert property (@(posedge clk)
    rst |=> (q == '0 && !data_valid));
  a_r8_reset_steer: assert property (@(negedge clk)
    rst |=> (cur_bank == BANK_A && tap_a == '0 && tap_b == '0));

  // R9: valid stays high once set
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> data_valid);
endmodule

bind subrange_adc_backend adc_be_checker #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .cur_bank(cur_bank), .tap_a(fine_tap_a), .tap_b(fine_tap_b),
  .q(out_q), .data_valid(data_valid)
);

// File: tb/tb_subrange_adc_backend.sv
`timescale 1ns/100ps
module tb_subrange_adc_backend;
  localparam int N = 14;
  // {code, coarse bubble mask, fine bubble mask}
  localparam logic [37:0] VEC [N] = '{
    {8'h00, 15'h0000, 15'h0000},
    {8'hFF, 15'h0000, 15'h0000},
    {8'h0F, 15'h0000, 15'h0000},
    {8'hF0, 15'h0000, 15'h0000},
    {8'h80, 15'h0000, 15'h0000},
    {8'h7F, 15'h0000, 15'h0000},
    {8'h5A, 15'h0000, 15'h0000},
    {8'hA5, 15'h0000, 15'h0000},
    {8'h37, 15'h0400, 15'h0000},
    {8'hC4, 15'h0000, 15'h0001},
    {8'h92, 15'h0010, 15'h4000},
    {8'h1E, 15'h0000, 15'h0080},
    {8'hE1, 15'h0001, 15'h0000},
    {8'h3C, 15'h0000, 15'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oe_n = 1'b0;
  logic [14:0] coarse_therm = '0;
  logic [14:0] fine_therm_a = '0;
  logic [14:0] fine_therm_b = '0;
  logic [3:0]  fine_tap_a, fine_tap_b;
  logic        data_valid;
  wire  [7:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subrange_adc_backend dut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .coarse_therm(coarse_therm),
    .fine_therm_a(fine_therm_a), .fine_therm_b(fine_therm_b),
    .fine_tap_a(fine_tap_a), .fine_tap_b(fine_tap_b),
    .data_valid(data_valid), .dout(dout)
  );

  function automatic logic [14:0] therm(input logic [3:0] v);
    logic [14:0] t;
    for (int i = 0; i < 15; i++) t[i] = (i < v);
    return t;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8 dout", 32'(dout), 32'h00);
    chk("R8 valid", 32'(data_valid), 0);
    chk("R8 tap_a", 32'(fine_tap_a), 0);
    chk("R8 tap_b", 32'(fine_tap_b), 0);

    for (int t = 0; t < N + 2; t++) begin
      if (t == 0) rst = 1'b0;
      // sample t on coarse; fine word of sample t-1 on its bank (R3: even A, odd B)
      if (t < N) coarse_therm = therm(VEC[t][37:34]) ^ VEC[t][29:15];
      if (t >= 1 && t - 1 < N) begin
        if ((t - 1) % 2 == 0) fine_therm_a = therm(VEC[t-1][33:30]) ^ VEC[t-1][14:0];
        else                  fine_therm_b = therm(VEC[t-1][33:30]) ^ VEC[t-1][14:0];
      end
      @(posedge clk);
      #1;
      if (t < 2) begin
        // R9: nothing valid before the first sample completes
        chk("R9 valid low", 32'(data_valid), 0);
        chk("R8 dout zero", 32'(dout), 32'h00);
      end else begin
        // R1 R2 R5 R6: one result per cycle, 2.5-cycle latency, bubbles corrected
        chk("R9 valid high", 32'(data_valid), 1);
        chk("R2 dout", 32'(dout), 32'(VEC[t-2][37:30]));
      end
      // R4: tap of the sampling bank updated, other bank held
      if (t < N) begin
        if (t % 2 == 0) chk("R4 tap_a", 32'(fine_tap_a), 32'(VEC[t][37:34]));
        else            chk("R4 tap_b", 32'(fine_tap_b), 32'(VEC[t][37:34]));
      end
      if (t >= 1 && t - 1 < N) begin
        if ((t - 1) % 2 == 0) chk("R3 tap_a hold", 32'(fine_tap_a), 32'(VEC[t-1][37:34]));
        else                  chk("R3 tap_b hold", 32'(fine_tap_b), 32'(VEC[t-1][37:34]));
      end
      if (t == 6) begin
        // R7: three-state when disabled, drives again when enabled
        oe_n = 1'b1;
        #0.4;
        checks++;
        if (dout !== 8'hzz) begin
          errors++;
          $display("FAIL R7 float: actual %0h expected zz", dout);
        end
        oe_n = 1'b0;
        #0.2;
        chk("R7 drive", 32'(dout), 32'(VEC[t-2][37:30]));
      end
    end

    // R8: reset in mid-stream clears everything
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 mid dout", 32'(dout), 32'h00);
    chk("R8 mid valid", 32'(data_valid), 0);
    chk("R8 mid tap_a", 32'(fine_tap_a), 0);
    chk("R8 mid tap_b", 32'(fine_tap_b), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule